// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a precision time-of-day value as a 48-bit seconds count and a 30-bit nanoseconds count. On every clock edge the time advances by a programmable step. The step is a fixed-point value with an 8-bit whole-nanosecond part and a 16-bit fraction. The fraction accumulates in a private register, and each time that register overflows one extra nanosecond is added. When the nanoseconds reach one billion they wrap and carry one into the seconds.

Software drives the block through a word-addressed bus with single-cycle write and read strobes. Through it software can:
- set the time;
- program the step, where the fractional part is staged and committed together with the whole part;
- apply a one-shot signed nanosecond offset;
- read back the live time and the active step.

The nominal step for a timer clock of rate F is 1e9/F nanoseconds. The whole quotient goes in the integer field. The remainder, scaled by 2^16 and divided by F, goes in the fraction field.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the seconds, nanoseconds, both step fields, the staged fraction and bus_rdata are all zero.
- R2: On each edge the 16-bit fraction accumulator adds the active fraction modulo 2^16. The nanoseconds advance by the active integer step, plus one when that 16-bit sum overflowed.
- R3: When an update brings the nanoseconds to 1,000,000,000 or more, they lose 1,000,000,000 and the seconds (modulo 2^48) gain one.
- R4: A write to address 3 (bits 15:0) only stages a fraction. A write to address 4 (bits 7:0) makes its value the active integer step and the staged fraction the active fraction at the same time. Both take effect from the following edge.
- R5: A write to address 2 holds bits 15:0 as upper seconds without changing the time. A write to address 1 loads seconds = {held upper, wdata}. This load takes priority over any carry or borrow in the same cycle.
- R6: A write to address 0 with a value below 1,000,000,000 replaces that cycle's update: the nanoseconds become the value and no carry occurs. A larger value is ignored and the normal update proceeds.
- R7: A write to address 5 adds a signed offset to that cycle's update. Bit 31 set means subtract, and bits 29:0 hold a magnitude below 1e9. A result below zero gains 1e9 and borrows one second. A result of 1e9 or more wraps and carries.
- R8: An all-zero active step with no write holds the time still. A write of zero magnitude to address 5, with either sign, leaves the update unchanged.
- R9: A read strobe returns, one edge later and held until the next read, the value at that edge, selected by address:
  - address 0: nanoseconds;
  - address 1: seconds bits 31:0;
  - address 2: seconds bits 47:32;
  - address 3: active fraction;
  - address 4: active integer step;
  - any other address: zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; one update per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tod_sec | output | 48 | Live seconds count |
| tod_ns | output | 30 | Live nanoseconds count |

## Verification
The accumulator, the held upper seconds and the staged fraction are all invisible at the ports. The bench therefore runs a behavioural model on every edge and compares the live time and the read data against it.

Each hidden fault shows up at a predictable point:
- A wrong accumulator value appears as a one-nanosecond slip at the next fraction overflow, which can be up to 65536 edges later.
- A wrong held upper seconds value appears only when the low seconds are next loaded.
- A wrong staged fraction appears only after the next integer-step commit.
- Carry, borrow and load-priority faults show in tod_sec on the very edge where they happen.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

  localparam int unsigned NS_PER_SEC = 1_000_000_000;
  localparam int NS_W = 30;
  localparam int NUM_REGS = 6;

  localparam int REG_NS       = 0;
  localparam int REG_SEC_LO   = 1;
  localparam int REG_SEC_HI   = 2;
  localparam int REG_INC_FRAC = 3;
  localparam int REG_INC_INT  = 4;
  localparam int REG_ADJ      = 5;

  localparam logic signed [NS_W+3:0] NSEC_S = (NS_W+4)'(NS_PER_SEC);

  typedef struct packed {
    logic [NS_W-1:0] ns;
    logic            up;
    logic            down;
  } ns_step_t;

  // one update of the nanosecond count: step plus signed offset, then fold
  function automatic ns_step_t ns_advance(logic [NS_W-1:0] ns,
                                          logic [NS_W-1:0] step,
                                          logic            neg,
                                          logic [NS_W-1:0] mag);
    logic signed [NS_W+3:0] v;
    ns_step_t r;
    v = $signed({4'b0, ns}) + $signed({4'b0, step});
    if (neg) v = v - $signed({4'b0, mag});
    else     v = v + $signed({4'b0, mag});
    r.up   = 1'b0;
    r.down = 1'b0;
    if (v[NS_W+3]) begin
      v = v + NSEC_S;
      r.down = 1'b1;
    end else if (v >= NSEC_S) begin
      v = v - NSEC_S;
      r.up = 1'b1;
    end
    r.ns = v[NS_W-1:0];
    return r;
  endfunction

endpackage

// File: rtl/ptp_tod_bus.sv
module ptp_tod_bus
  import ptp_tod_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int SEC_W  = 48,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NS_W-1:0]     ns_i,
  input  logic [SEC_W-1:0]    sec_i,
  input  logic [INT_W-1:0]    act_int_i,
  input  logic [FRAC_W-1:0]   act_frac_i,
  output logic [NUM_REGS-1:0] wr_sel_o,
  output logic [DATA_W-1:0]   rdata_o
);

  logic [DATA_W-1:0] rd_mux;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign wr_sel_o[g] = bus_wr && (bus_addr == ADDR_W'(g));
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(REG_NS):       rd_mux = DATA_W'(ns_i);
      ADDR_W'(REG_SEC_LO):   rd_mux = sec_i[DATA_W-1:0];
      ADDR_W'(REG_SEC_HI):   rd_mux = DATA_W'(sec_i[SEC_W-1:DATA_W]);
      ADDR_W'(REG_INC_FRAC): rd_mux = DATA_W'(act_frac_i);
      ADDR_W'(REG_INC_INT):  rd_mux = DATA_W'(act_int_i);
      default:               rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_o <= '0;
    else if (bus_rd) rdata_o <= rd_mux;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(rdata_o)); // R9

endmodule

// File: rtl/ptp_tod_incr.sv
module ptp_tod_incr #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_frac,
  input  logic              wr_int,
  input  logic [DATA_W-1:0] wdata,
  output logic [INT_W:0]    step_o,
  output logic [INT_W-1:0]  act_int_o,
  output logic [FRAC_W-1:0] act_frac_o
);

  logic [FRAC_W-1:0] stage_q, act_frac_q, acc_q;
  logic [INT_W-1:0]  act_int_q;
  logic [FRAC_W:0]   frac_sum;
  logic              frac_carry;

  assign frac_sum   = {1'b0, acc_q} + {1'b0, act_frac_q};
  assign frac_carry = frac_sum[FRAC_W];
  assign step_o     = {1'b0, act_int_q} + {{INT_W{1'b0}}, frac_carry};
  assign act_int_o  = act_int_q;
  assign act_frac_o = act_frac_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q    <= '0;
      act_frac_q <= '0;
      act_int_q  <= '0;
      acc_q      <= '0;
    end else begin
      acc_q <= frac_sum[FRAC_W-1:0];
      if (wr_frac) stage_q <= wdata[FRAC_W-1:0];
      if (wr_int) begin
        act_int_q  <= wdata[INT_W-1:0];
        act_frac_q <= stage_q;
      end
    end
  end

  AST_FRAC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frac_carry |=> acc_q < $past(acc_q)); // R2
  AST_FRAC_NOWRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !frac_carry |=> acc_q >= $past(acc_q)); // R2
  AST_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_int |=> (act_frac_q == $past(stage_q))
               && (act_int_q == $past(wdata[INT_W-1:0]))); // R4
  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_int |=> $stable(act_frac_q) && $stable(act_int_q)); // R4

endmodule

// File: rtl/ptp_tod_time.sv
module ptp_tod_time
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int DATA_W = 32,
  parameter int STEP_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ns,
  input  logic              ld_sec_lo,
  input  logic              ld_sec_hi,
  input  logic              adj_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STEP_W-1:0] step_ns,
  output logic [NS_W-1:0]   ns_o,
  output logic [SEC_W-1:0]  sec_o
);

  localparam int HI_W = SEC_W - DATA_W;

  logic [HI_W-1:0]  hold_q;
  logic [NS_W-1:0]  ns_q;
  logic [SEC_W-1:0] sec_q;
  logic             adj_neg;
  logic [NS_W-1:0]  adj_mag;
  ns_step_t         adv;
  logic             ns_load_ok, roll_up, roll_down;

  assign adj_neg    = adj_en & wdata[DATA_W-1];
  assign adj_mag    = adj_en ? wdata[NS_W-1:0] : '0;
  assign ns_load_ok = ld_ns && (wdata < DATA_W'(NS_PER_SEC));
  assign adv        = ns_advance(ns_q, NS_W'(step_ns), adj_neg, adj_mag);
  assign roll_up    = adv.up & ~ns_load_ok;
  assign roll_down  = adv.down & ~ns_load_ok;
  assign ns_o       = ns_q;
  assign sec_o      = sec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      ns_q   <= '0;
      sec_q  <= '0;
    end else begin
      if (ld_sec_hi) hold_q <= wdata[HI_W-1:0];
      ns_q <= ns_load_ok ? wdata[NS_W-1:0] : adv.ns;
      if (ld_sec_lo)      sec_q <= {hold_q, wdata};
      else if (roll_up)   sec_q <= sec_q + SEC_W'(1);
      else if (roll_down) sec_q <= sec_q - SEC_W'(1);
    end
  end

  AST_NS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    DATA_W'(ns_q) < DATA_W'(NS_PER_SEC)); // R6
  AST_CARRY_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    roll_up && !ld_sec_lo |=> sec_q == $past(sec_q) + SEC_W'(1)); // R3
  AST_BORROW_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    roll_down && !ld_sec_lo |=> sec_q == $past(sec_q) - SEC_W'(1)); // R7
  AST_SEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sec_lo |=> sec_q[DATA_W-1:0] == $past(wdata)); // R5
  AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ns == '0) && !adj_en && !ld_ns && !ld_sec_lo
      |=> $stable(ns_q) && $stable(sec_q)); // R8

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int SEC_W  = 48,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns
);

  localparam int STEP_W = INT_W + 1;

  logic [NUM_REGS-1:0] wr_sel;
  logic [STEP_W-1:0]   step_ns;
  logic [INT_W-1:0]    act_int;
  logic [FRAC_W-1:0]   act_frac;

  ptp_tod_bus #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W),
    .INT_W(INT_W), .FRAC_W(FRAC_W)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .ns_i(tod_ns), .sec_i(tod_sec),
    .act_int_i(act_int), .act_frac_i(act_frac),
    .wr_sel_o(wr_sel), .rdata_o(bus_rdata)
  );

  ptp_tod_incr #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)
  ) u_incr (
    .clk(clk), .rst_n(rst_n),
    .wr_frac(wr_sel[REG_INC_FRAC]), .wr_int(wr_sel[REG_INC_INT]),
    .wdata(bus_wdata), .step_o(step_ns),
    .act_int_o(act_int), .act_frac_o(act_frac)
  );

  ptp_tod_time #(
    .SEC_W(SEC_W), .DATA_W(DATA_W), .STEP_W(STEP_W)
  ) u_time (
    .clk(clk), .rst_n(rst_n),
    .ld_ns(wr_sel[REG_NS]), .ld_sec_lo(wr_sel[REG_SEC_LO]),
    .ld_sec_hi(wr_sel[REG_SEC_HI]), .adj_en(wr_sel[REG_ADJ]),
    .wdata(bus_wdata), .step_ns(step_ns),
    .ns_o(tod_ns), .sec_o(tod_sec)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (tod_ns == '0) && (tod_sec == '0) && (bus_rdata == '0)); // R1

endmodule

// File: tb/tb_ptp_tod_counter.sv
module tb_ptp_tod_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  localparam longint BIL  = 1_000_000_000;
  localparam longint MASK48 = 64'h0000_FFFF_FFFF_FFFF;

  ptp_tod_counter dut (.*);

  always #5 clk = ~clk;

  // behavioural reference
  longint m_ns, m_sec, m_frac, m_int, m_sub, m_stage, m_hold, m_rd;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ns = 0; m_sec = 0; m_frac = 0; m_int = 0; m_sub = 0;
      m_stage = 0; m_hold = 0; m_rd = 0;
    end else begin
      longint f, st, v, d, w;
      w = longint'(bus_wdata);
      if (bus_rd) begin
        case (bus_addr)
          3'd0: m_rd = m_ns;
          3'd1: m_rd = m_sec & 64'hFFFF_FFFF;
          3'd2: m_rd = m_sec >> 32;
          3'd3: m_rd = m_sub;
          3'd4: m_rd = m_int;
          default: m_rd = 0;
        endcase
      end
      f = m_frac + m_sub;
      st = m_int + (f >> 16);
      m_frac = f % 65536;
      d = 0;
      if (bus_wr && bus_addr == 3'd0 && w < BIL) m_ns = w;
      else begin
        v = m_ns + st;
        if (bus_wr && bus_addr == 3'd5)
          v = bus_wdata[31] ? v - (w % (1 << 30)) : v + (w % (1 << 30));
        if (v < 0) begin v += BIL; d = -1; end
        else if (v >= BIL) begin v -= BIL; d = 1; end
        m_ns = v;
      end
      if (bus_wr && bus_addr == 3'd1) m_sec = (m_hold << 32) | w;
      else m_sec = (m_sec + d) & MASK48;
      if (bus_wr && bus_addr == 3'd2) m_hold = w & 64'hFFFF;
      if (bus_wr && bus_addr == 3'd3) m_stage = w & 64'hFFFF;
      if (bus_wr && bus_addr == 3'd4) begin m_int = w & 64'hFF; m_sub = m_stage; end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, longint act, longint lo, longint hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model ns", longint'(tod_ns), m_ns);
      chk("R3 model sec", longint'(tod_sec), m_sec);
      chk("R9 model rdata", longint'(bus_rdata), m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output longint v);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    v = longint'(bus_rdata);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    longint n0, s0, r, q, fr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ns", tod_ns, 0);
    chk("R1 sec", tod_sec, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(3'd4, r); chk("R1 int step", r, 0);
    rd(3'd3, r); chk("R1 frac step", r, 0);

    // R2 integer step
    wr(3'd4, 8);
    n0 = tod_ns; idle(10);
    chk("R2 eight per tick", tod_ns, n0 + 80);

    // R4 staging
    wr(3'd3, 32'h8000);
    rd(3'd3, r); chk("R4 frac still staged", r, 0);
    n0 = tod_ns; idle(4);
    chk("R4 no early effect", tod_ns, n0 + 32);
    wr(3'd4, 8);
    rd(3'd3, r); chk("R4 frac committed", r, 32'h8000);
    n0 = tod_ns; idle(8);
    chk("R2 half-ns fraction", tod_ns, n0 + 68);

    // R2 nominal step for a 300 MHz clock
    q = BIL / 300_000_000;
    fr = ((BIL % 300_000_000) << 16) / 300_000_000;
    wr(3'd3, 32'(fr)); wr(3'd4, 32'(q));
    wr(3'd0, 0);
    n0 = tod_ns; idle(1000);
    chk_rng("R2 fractional drift", tod_ns - n0, 3333, 3334);

    // R5 held upper seconds, then load
    wr(3'd3, 0); wr(3'd4, 8);
    wr(3'd0, 0);
    s0 = tod_sec;
    wr(3'd2, 32'h0012);
    chk("R5 upper only held", tod_sec, s0);
    wr(3'd1, 32'hFFFF_FFFF);
    chk("R5 seconds loaded", tod_sec, 64'h12_FFFF_FFFF);

    // R3 carry across the 32-bit seconds boundary
    wr(3'd0, 999_999_984);
    chk("R6 ns loaded", tod_ns, 999_999_984);
    idle(2);
    chk("R3 ns wrapped", tod_ns, 0);
    chk("R3 seconds carried", tod_sec, 64'h13_0000_0000);

    // R6 out-of-range ns write ignored
    n0 = tod_ns;
    wr(3'd0, 1_000_000_000);
    chk("R6 bad ns ignored", tod_ns, n0 + 8);

    // R7 adjust up, down with borrow, up with carry
    n0 = tod_ns;
    wr(3'd5, 100);
    chk("R7 add offset", tod_ns, n0 + 108);
    n0 = tod_ns; s0 = tod_sec;
    wr(3'd5, 32'h8000_0000 | 500);
    chk("R7 borrow ns", tod_ns, n0 + 8 - 500 + BIL);
    chk("R7 borrow sec", tod_sec, s0 - 1);
    n0 = tod_ns; s0 = tod_sec;
    wr(3'd5, 600);
    chk("R7 carry ns", tod_ns, n0 + 608 - BIL);
    chk("R7 carry sec", tod_sec, s0 + 1);

    // R8 zero adjust both signs
    n0 = tod_ns;
    wr(3'd5, 0);
    chk("R8 zero adjust", tod_ns, n0 + 8);
    n0 = tod_ns;
    wr(3'd5, 32'h8000_0000);
    chk("R8 negative zero adjust", tod_ns, n0 + 8);

    // R5 seconds load beats a carry in the same cycle
    wr(3'd2, 0);
    wr(3'd0, 999_999_996);
    wr(3'd1, 32'h55);
    chk("R5 load over carry sec", tod_sec, 32'h55);
    chk("R5 load over carry ns", tod_ns, 4);

    // R9 read of the live count
    n0 = tod_ns;
    rd(3'd0, r); chk("R9 live ns read", r, n0);
    s0 = tod_sec;
    rd(3'd2, r); chk("R9 upper seconds read", r, s0 >> 32);
    rd(3'd7, r); chk("R9 unused address", r, 0);

    // R8 zero step stops the count
    wr(3'd3, 0); wr(3'd4, 0);
    n0 = tod_ns; s0 = tod_sec;
    idle(20);
    chk("R8 stopped ns", tod_ns, n0);
    chk("R8 stopped sec", tod_sec, s0);
    rd(3'd1, r); chk("R9 seconds low read", r, s0 & 64'hFFFF_FFFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule